// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block turns the set of exception requests pending in a CPU subsystem into the 16-bit address of the vector the CPU fetches next. It handles four request classes: reset requests, the non-maskable trap and software-interrupt requests, one request that the CPU's X bit can mask, and a parameterised set of peripheral requests that the CPU's I bit can mask, each with its own local enable. The vector address itself sets the priority: the higher address wins, and the winner is chosen only at the moment the CPU strobes for a vector. Any request that arrives before that strobe can therefore take the place of the one that started the vector fetch.

An 8-bit base register, written through a synchronous write port, supplies the upper address byte. Each source has a fixed, word-aligned lower byte. The reset vectors always use an upper byte of 0xFF. While the debug-active input is high, every vector uses an upper byte of 0xFF, whatever the base register holds. If nothing is eligible when the strobe arrives, the block returns a defined spurious vector.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset, the base register holds 0xFF, `vec_valid` is 0 and `vec_addr` is 0x0000.
- R2: `vec_valid` is high for exactly the one cycle after each cycle in which `vec_req` is high. At that point `vec_addr` holds the new vector, and its bit 0 is 0. `vec_addr` keeps its value until the next request.
- R3: Reset requests outrank every other request. `reset_req[k]` gives lower byte 0xFE−2k (0xFE, 0xFC, 0xFA), and a lower index wins. The upper byte of a reset vector is always 0xFF, whatever the base register holds.
- R4: The non-I-maskable requests rank trap (lower byte 0x78) above software interrupt (0x76) above the X-maskable request (0x74). All three outrank every I-maskable request.
- R5: The X-maskable request is eligible only while `x_mask` is 0.
- R6: Peripheral source i has lower byte 0x72−2i. It is eligible only when `irq_req[i]`, `irq_en[i]` and `i_mask`=0 all hold. Among eligible sources, the lowest index (the highest address) wins.
- R7: While `trap_req`, `swi_req` or `xirq_req` is high, no I-maskable source is eligible. This holds even when `x_mask` is 1.
- R8: When nothing is eligible, the lower byte is the spurious value 0x00.
- R9: For every vector that is not a reset vector, the upper byte is the base register. A write through `base_wr` takes effect from the next request. A request strobed in the same cycle as a write still uses the old base.
- R10: While `dbg_active` is high at the strobe, the upper byte is 0xFF.
- R11: The vector reflects the request inputs in the strobe cycle only. A request that rose or fell earlier has no effect of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 3 | Reset requests, index 0 highest |
| trap_req | input | 1 | Trap request |
| swi_req | input | 1 | Software interrupt request |
| xirq_req | input | 1 | X-maskable request |
| x_mask | input | 1 | CPU X mask bit (1 = masked) |
| irq_req | input | N_IRQ | Peripheral requests |
| irq_en | input | N_IRQ | Peripheral local enables |
| i_mask | input | 1 | CPU I mask bit (1 = masked) |
| dbg_active | input | 1 | Debug mode active |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 8 | Base register write data |
| vec_req | input | 1 | One-cycle vector request strobe |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_addr | output | 16 | Resolved vector address |

## Verification
The case that needs care is a base-register write that falls in the same cycle as a vector strobe. The bench drives both in one cycle and expects the vector to carry the old upper byte; the very next strobe must carry the new one. The debug override meets a programmed base in the same way: a strobe taken with `dbg_active` high must yield 0xFF even though the base differs, and the base must reappear once debug mode drops.

// File: rtl/intc_pkg.sv
// Package: shared constants, offset functions and the decoder result type
// for the vectored interrupt priority controller.
package intc_pkg;
    localparam int          RST_SRCS  = 3;
    localparam logic [7:0]  OFS_TRAP  = 8'h78;
    localparam logic [7:0]  OFS_SWI   = 8'h76;
    localparam logic [7:0]  OFS_XIRQ  = 8'h74;
    localparam int          IRQ_TOP   = 'h72;
    localparam logic [7:0]  OFS_SPUR  = 8'h00;
    localparam logic [7:0]  HI_FIXED  = 8'hFF;

    // Lower byte of reset vector k
    function automatic logic [7:0] rst_ofs(input int k);
        return 8'(8'hFE - 2 * k);
    endfunction

    // Lower byte of peripheral vector i
    function automatic logic [7:0] irq_ofs(input int i);
        return 8'(IRQ_TOP - 2 * i);
    endfunction

    // Decoder result: lower byte and whether the upper byte is forced
    typedef struct packed {
        logic       fixed_hi;
        logic [7:0] ofs;
    } pick_t;
endpackage

// File: rtl/intc_base_reg.sv
// Module: intc_base_reg
// Holds the 8-bit vector base byte. Assumes writes are single-cycle strobes;
// a write is visible from the cycle after it is taken.
module intc_base_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] base
);
    // Load the base byte on reset or on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= 8'hFF;
        else if (wr)
            base <= wdata;
    end
endmodule

// File: rtl/intc_prio_dec.sv
// Module: intc_prio_dec
// Combinational priority decoder. Picks the eligible request with the
// highest vector address. Assumes every peripheral offset is above the
// spurious offset (N_IRQ <= 57).
module intc_prio_dec
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic [RST_SRCS-1:0] reset_req,
    input  logic                trap_req,
    input  logic                swi_req,
    input  logic                xirq_req,
    input  logic                x_mask,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic                i_mask,
    output pick_t               pick
);
    logic             i_open;
    logic [N_IRQ-1:0] irq_elig;

    // I-maskable requests open only when unmasked and no higher class is raised
    always_comb i_open = !i_mask && !trap_req && !swi_req && !xirq_req;

    // Per-source eligibility
    for (genvar g = 0; g < N_IRQ; g++) begin : g_elig
        assign irq_elig[g] = irq_req[g] && irq_en[g] && i_open;
    end

    // Scan from lowest to highest priority; later hits override earlier ones
    always_comb begin
        pick.fixed_hi = 1'b0;
        pick.ofs      = OFS_SPUR;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irq_elig[i]) pick.ofs = irq_ofs(i);
        end
        if (xirq_req && !x_mask) pick.ofs = OFS_XIRQ;
        if (swi_req)             pick.ofs = OFS_SWI;
        if (trap_req)            pick.ofs = OFS_TRAP;
        for (int k = RST_SRCS - 1; k >= 0; k--) begin
            if (reset_req[k]) begin
                pick.ofs      = rst_ofs(k);
                pick.fixed_hi = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_vec_out.sv
// Module: intc_vec_out
// Registers the resolved vector on a request strobe and drives the valid
// pulse. Assumes vec_req is a single-cycle strobe.
module intc_vec_out
    import intc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_req,
    input  pick_t       pick,
    input  logic [7:0]  base,
    input  logic        dbg_active,
    output logic        vec_valid,
    output logic [15:0] vec_addr
);
    logic [7:0] hi_byte;

    // Choose the upper byte: forced for reset vectors and in debug mode
    always_comb hi_byte = (pick.fixed_hi || dbg_active) ? HI_FIXED : base;

    // Capture the vector at the strobe and pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= 16'h0000;
        end else begin
            vec_valid <= vec_req;
            if (vec_req) vec_addr <= {hi_byte, pick.ofs[7:1], 1'b0};
        end
    end
endmodule

// File: rtl/intc_vector_ctrl.sv
// Module: intc_vector_ctrl (top)
// Resolves pending exception requests into a vector address when the CPU
// strobes vec_req. Assumes all request inputs are synchronous to clk.
module intc_vector_ctrl
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RST_SRCS-1:0] reset_req,
    input  logic                trap_req,
    input  logic                swi_req,
    input  logic                xirq_req,
    input  logic                x_mask,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic                i_mask,
    input  logic                dbg_active,
    input  logic                base_wr,
    input  logic [7:0]          base_wdata,
    input  logic                vec_req,
    output logic                vec_valid,
    output logic [15:0]         vec_addr
);
    logic [7:0] base;
    pick_t      pick;

    intc_base_reg u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (base_wr),
        .wdata (base_wdata),
        .base  (base)
    );

    intc_prio_dec #(.N_IRQ(N_IRQ)) u_dec (
        .reset_req (reset_req),
        .trap_req  (trap_req),
        .swi_req   (swi_req),
        .xirq_req  (xirq_req),
        .x_mask    (x_mask),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .i_mask    (i_mask),
        .pick      (pick)
    );

    intc_vec_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_req    (vec_req),
        .pick       (pick),
        .base       (base),
        .dbg_active (dbg_active),
        .vec_valid  (vec_valid),
        .vec_addr   (vec_addr)
    );
endmodule

// File: rtl/intc_vector_chk.sv
// Module: intc_vector_chk
// Checker bound to the top. Relates the request inputs at a strobe to the
// vector output in the following cycle.
module intc_vector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  reset_req,
    input logic        trap_req,
    input logic        swi_req,
    input logic        xirq_req,
    input logic        x_mask,
    input logic        i_mask,
    input logic        dbg_active,
    input logic        vec_req,
    input logic        vec_valid,
    input logic [15:0] vec_addr
);
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> vec_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> !vec_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> $stable(vec_addr));
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !vec_addr[0]);
    p_reset_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && |reset_req) |=> (vec_addr[15:8] == 8'hFF && vec_addr[7:0] >= 8'hFA));
    p_trap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !(|reset_req) && trap_req) |=> (vec_addr[7:0] == 8'h78));
    p_debug_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && dbg_active) |=> (vec_addr[15:8] == 8'hFF));
    p_imask_spur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && i_mask && !(|reset_req) && !trap_req && !swi_req
         && !(xirq_req && !x_mask)) |=> (vec_addr[7:0] == 8'h00));
endmodule

bind intc_vector_ctrl intc_vector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_req  (reset_req),
    .trap_req   (trap_req),
    .swi_req    (swi_req),
    .xirq_req   (xirq_req),
    .x_mask     (x_mask),
    .i_mask     (i_mask),
    .dbg_active (dbg_active),
    .vec_req    (vec_req),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr)
);

// File: tb/tb_intc_vector_ctrl.sv
module tb_intc_vector_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   reset_req = '0;
    logic         trap_req = 1'b0, swi_req = 1'b0, xirq_req = 1'b0;
    logic         x_mask = 1'b1, i_mask = 1'b1, dbg_active = 1'b0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic         base_wr = 1'b0;
    logic [7:0]   base_wdata = '0;
    logic         vec_req = 1'b0;
    logic         vec_valid;
    logic [15:0]  vec_addr;

    int  checks = 0, fails = 0;
    bit  done = 0;
    logic [7:0] base_m = 8'hFF;

    always #5 clk = ~clk;

    intc_vector_ctrl #(.N_IRQ(N)) dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .trap_req(trap_req),
        .swi_req(swi_req), .xirq_req(xirq_req), .x_mask(x_mask),
        .irq_req(irq_req), .irq_en(irq_en), .i_mask(i_mask),
        .dbg_active(dbg_active), .base_wr(base_wr), .base_wdata(base_wdata),
        .vec_req(vec_req), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        reset_req = '0; trap_req = 0; swi_req = 0; xirq_req = 0;
        x_mask = 1; i_mask = 1; dbg_active = 0; irq_req = '0; irq_en = '0;
    endtask

    // Strobe once and check the registered vector and the valid pulse
    task automatic strobe(input logic [15:0] exp, input string req);
        @(negedge clk); vec_req = 1;
        @(negedge clk); vec_req = 0;
        chk({15'b0, vec_valid}, 16'd1, "R2");
        chk(vec_addr, exp, req);
        @(negedge clk);
        chk({15'b0, vec_valid}, 16'd0, "R2");
        chk(vec_addr, exp, "R2");
    endtask

    task automatic write_base(input logic [7:0] v);
        @(negedge clk); base_wr = 1; base_wdata = v;
        @(negedge clk); base_wr = 0;
        base_m = v;
    endtask

    task automatic t_reset_state();
        chk({15'b0, vec_valid}, 16'd0, "R1");
        chk(vec_addr, 16'h0000, "R1");
        strobe({base_m, 8'h00}, "R1_R8");
    endtask

    task automatic t_reset_vectors();
        write_base(8'h12);
        clear_inputs(); trap_req = 1; reset_req = 3'b110;
        strobe(16'hFFFC, "R3");
        reset_req = 3'b001;
        strobe(16'hFFFE, "R3");
        reset_req = 3'b100;
        strobe(16'hFFFA, "R3");
        clear_inputs();
    endtask

    task automatic t_nonmask_order();
        clear_inputs(); x_mask = 0; i_mask = 0; irq_req = '1; irq_en = '1;
        trap_req = 1; swi_req = 1; xirq_req = 1;
        strobe({base_m, 8'h78}, "R4");
        trap_req = 0;
        strobe({base_m, 8'h76}, "R4");
        swi_req = 0;
        strobe({base_m, 8'h74}, "R4_R5");
        clear_inputs();
    endtask

    task automatic t_xmask();
        clear_inputs(); xirq_req = 1; x_mask = 1;
        strobe({base_m, 8'h00}, "R5");
        i_mask = 0; irq_req = 8'h01; irq_en = 8'h01;
        strobe({base_m, 8'h00}, "R7");
        clear_inputs();
    endtask

    task automatic t_imask();
        clear_inputs(); i_mask = 0; irq_req = 8'hA0; irq_en = 8'hFF;
        strobe({base_m, 8'h68}, "R6");
        irq_en = 8'hDF;
        strobe({base_m, 8'h64}, "R6");
        i_mask = 1;
        strobe({base_m, 8'h00}, "R6_R8");
        clear_inputs();
    endtask

    task automatic t_base_write();
        clear_inputs(); i_mask = 0; irq_req = 8'h01; irq_en = 8'h01;
        write_base(8'h40);
        strobe(16'h4072, "R9");
        @(negedge clk); base_wr = 1; base_wdata = 8'h55; vec_req = 1;
        @(negedge clk); base_wr = 0; vec_req = 0;
        chk(vec_addr, 16'h4072, "R9");
        base_m = 8'h55;
        strobe(16'h5572, "R9");
        clear_inputs();
    endtask

    task automatic t_debug();
        clear_inputs(); i_mask = 0; irq_req = 8'h02; irq_en = 8'h02; dbg_active = 1;
        strobe(16'hFF70, "R10");
        dbg_active = 0;
        strobe({base_m, 8'h70}, "R10");
        clear_inputs();
    endtask

    task automatic t_late_sample();
        clear_inputs(); i_mask = 0; irq_en = 8'hFF; irq_req = 8'h80;
        repeat (3) @(negedge clk);
        irq_req = 8'h81;
        strobe({base_m, 8'h72}, "R11");
        irq_req = 8'h00;
        repeat (2) @(negedge clk);
        strobe({base_m, 8'h00}, "R11");
        clear_inputs();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_reset_vectors();
        t_nonmask_order();
        t_xmask();
        t_imask();
        t_base_write();
        t_debug();
        t_late_sample();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule